// File: doc/BRIEF.md
# Flow-Control Calendar Sequencer

This block produces the per-port flow-control status stream of a packet interface that reports receive-buffer fill to its link partner. A programmable calendar lists the order in which ports are reported. Every cycle the block emits one word of the stream together with a kind tag. The word is a framing word, a slot word carrying the status of the port named by the current calendar entry, or a closing 2-bit parity word. The live per-port status levels arrive on a flat input vector.

Two calendar copies exist. One drives the stream while software rewrites the other through a one-entry-per-cycle write port. A swap request is held until the current sequence has closed with its parity word. The two copies then trade roles, together with a new length and repetition count, at that boundary. The stream never loses or corrupts a slot. A single-cycle acknowledge marks the framing word that opens the first sequence on the new calendar.

Top module: `fc_cal_seq`

## Requirements
- R1: After reset the block is idle: `out_kind` = 0 (idle), `out_code` = 0, `out_port` = 0, `swap_ack` = 0, `wr_err` = 0. It stays idle until the first swap request has been accepted.
- R2: Once started, sequences run back to back. Each sequence is one framing cycle (`out_kind` = 1, `out_code` = 2'b11), then length×repeat slot cycles (`out_kind` = 2), then one parity cycle (`out_kind` = 3).
- R3: In slot cycles, `out_port` walks active-calendar entries 0 to length−1 in address order, and that walk is repeated `repeat` times within the sequence.
- R4: In a slot cycle, `out_code` is the status of port p, taken from `port_stat[2p+1:2p]`: 00 starving, 01 hungry, 10 satisfied. The reserved input value 11 is sent as 00, so a slot never carries the framing value.
- R5: The parity cycle carries the bitwise XOR of every slot code sent in that sequence, as sent.
- R6: Writes go only to the shadow copy. They have no effect on the running stream.
- R7: A swap request is held. It takes effect at the first boundary after a parity cycle, or immediately when idle. The sequence in flight completes on the old calendar. `swap_ack` is high for exactly one cycle, during the first framing word on the new calendar.
- R8: A write issued while a swap is pending is discarded: the shadow entry keeps its old value, and `wr_err` pulses high in the following cycle.
- R9: `sh_len` and `sh_rep` are captured only at a swap. A length of 0 becomes 1, a length above the calendar depth becomes the depth, and a repeat of 0 becomes 1. Changes to these inputs between swaps have no effect.
- R10: A swap requested from idle starts the first framing word two cycles after the request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_stat | input | 2*NPORT | Live 2-bit status per port |
| wr_en | input | 1 | Shadow calendar write strobe |
| wr_addr | input | ADDR_W | Shadow entry address |
| wr_data | input | PORT_W | Port number to store |
| wr_err | output | 1 | Write was rejected (swap pending) |
| sh_len | input | LEN_W | Length for the next calendar |
| sh_rep | input | REP_W | Repeat count for the next calendar |
| swap_req | input | 1 | Request to exchange the calendars |
| swap_ack | output | 1 | Swap done, first framing word of new calendar |
| out_kind | output | 2 | 0 idle, 1 framing, 2 slot, 3 parity |
| out_port | output | PORT_W | Port of the current slot, 0 otherwise |
| out_code | output | 2 | Word on the status stream |

## Verification
The bench places swap requests at random slot positions, including the very first slot. It follows each request with a rejected write, so a design that swaps mid-sequence shows the wrong port in the remaining slots, and a design that accepts the blocked write shows a changed entry later. It also runs a length-1 calendar, where the blocked write lands in the parity cycle itself. It switches to a full-depth calendar reached through an over-range length, and to a calendar reached through zero length and zero repeat. Miscounting any of these gives a wrong slot count or a misplaced parity word. Every status draw may include the reserved value, and the parity is recomputed for each sequence before and after a swap. A design that forgets the substitution, or keeps its parity across a boundary, therefore emits a wrong code.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   // phase encoding doubles as the stream kind tag
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FRAME = 2'd1,
      PH_SLOT  = 2'd2,
      PH_DIP   = 2'd3
   } phase_t;

   localparam logic [1:0] FRAME_CODE = 2'b11;
   localparam logic [1:0] STAT_STARVE = 2'b00;

   function automatic int unsigned clamp_len(int unsigned raw, int unsigned depth);
      if (raw == 0) return 1;
      if (raw > depth) return depth;
      return raw;
   endfunction

   function automatic int unsigned clamp_rep(int unsigned raw);
      return (raw == 0) ? 1 : raw;
   endfunction

endpackage

// File: rtl/fcs_cal_store.sv
module fcs_cal_store #(
   parameter int DEPTH  = 1024,
   parameter int PORT_W = 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              act_bank,
   input  logic              wr_ok,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PORT_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [PORT_W-1:0] rd_port
);

   logic [PORT_W-1:0] bank_rd [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [PORT_W-1:0] mem [DEPTH];
      // only the bank that is not active takes writes
      always_ff @(posedge clk) begin
         if (wr_ok && (act_bank != 1'(b)))
            mem[wr_addr] <= wr_data;
      end
      assign bank_rd[b] = mem[rd_addr];
   end

   assign rd_port = act_bank ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/fcs_seq_ctrl.sv
module fcs_seq_ctrl
   import fcs_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int REP_W = 4,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LEN_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap_req,
   input  logic              wr_en,
   input  logic [LEN_W-1:0]  sh_len,
   input  logic [REP_W-1:0]  sh_rep,
   output phase_t            phase,
   output logic [ADDR_W-1:0] idx,
   output logic              bank,
   output logic              wr_ok,
   output logic              wr_err,
   output logic              swap_ack
);

   logic [LEN_W-1:0]  len_r;
   logic [REP_W-1:0]  rep_r;
   logic [REP_W-1:0]  rcnt;
   logic              pending;
   logic              do_swap;
   logic [LEN_W-1:0]  len_eff;
   logic [REP_W-1:0]  rep_eff;
   logic [ADDR_W-1:0] last_idx;
   logic [REP_W-1:0]  last_rep;

   assign do_swap  = pending && (phase == PH_IDLE || phase == PH_DIP);
   assign wr_ok    = wr_en && !pending;
   assign len_eff  = LEN_W'(clamp_len(int'(sh_len), DEPTH));
   assign rep_eff  = REP_W'(clamp_rep(int'(sh_rep)));
   assign last_idx = ADDR_W'(len_r - LEN_W'(1));
   assign last_rep = rep_r - REP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         idx      <= '0;
         rcnt     <= '0;
         bank     <= 1'b0;
         len_r    <= LEN_W'(1);
         rep_r    <= REP_W'(1);
         pending  <= 1'b0;
         swap_ack <= 1'b0;
         wr_err   <= 1'b0;
      end else begin
         swap_ack <= do_swap;
         wr_err   <= wr_en && pending;
         pending  <= (pending && !do_swap) || swap_req;
         if (do_swap) begin
            bank  <= ~bank;
            len_r <= len_eff;
            rep_r <= rep_eff;
         end
         unique case (phase)
            PH_IDLE:  if (pending) phase <= PH_FRAME;
            PH_FRAME: begin
               phase <= PH_SLOT;
               idx   <= '0;
               rcnt  <= '0;
            end
            PH_SLOT: begin
               if (idx == last_idx) begin
                  idx <= '0;
                  if (rcnt == last_rep) phase <= PH_DIP;
                  else                  rcnt  <= rcnt + REP_W'(1);
               end else begin
                  idx <= idx + ADDR_W'(1);
               end
            end
            PH_DIP:   phase <= PH_FRAME;
         endcase
      end
   end

   // R7: acknowledge only on the opening framing word
   p_ack_on_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swap_ack |-> phase == PH_FRAME);
   // R7: acknowledge is a single pulse
   p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swap_ack |=> !swap_ack);
   // R6: active bank moves only with a swap
   p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_ack |-> $stable(bank));
   // R2: parity word is always followed by a framing word
   p_dip_then_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_DIP |=> phase == PH_FRAME);
   // R8: error flag only follows a write attempt
   p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));
   // R3: slot index stays within the programmed length
   p_idx_in_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_SLOT |-> LEN_W'(idx) < len_r);

endmodule

// File: rtl/fcs_status_path.sv
module fcs_status_path
   import fcs_pkg::*;
#(
   parameter int NPORT = 256,
   localparam int PORT_W = $clog2(NPORT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*NPORT-1:0]  port_stat,
   input  logic [PORT_W-1:0]   port,
   input  logic                clr,
   input  logic                slot_en,
   output logic [1:0]          slot_code,
   output logic [1:0]          dip
);

   logic [1:0] raw;

   assign raw       = port_stat[{port, 1'b0} +: 2];
   assign slot_code = (raw == FRAME_CODE) ? STAT_STARVE : raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dip <= 2'b00;
      else if (clr)     dip <= 2'b00;
      else if (slot_en) dip <= dip ^ slot_code;
   end

   // R4: a slot never carries the framing value
   p_slot_not_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_en |-> slot_code != FRAME_CODE);

endmodule

// File: rtl/fc_cal_seq.sv
module fc_cal_seq
   import fcs_pkg::*;
#(
   parameter int MAX_SLOTS = 1024,
   parameter int NPORT     = 256,
   parameter int REP_W     = 4,
   localparam int ADDR_W = $clog2(MAX_SLOTS),
   localparam int LEN_W  = $clog2(MAX_SLOTS + 1),
   localparam int PORT_W = $clog2(NPORT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*NPORT-1:0] port_stat,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [PORT_W-1:0]  wr_data,
   output logic               wr_err,
   input  logic [LEN_W-1:0]   sh_len,
   input  logic [REP_W-1:0]   sh_rep,
   input  logic               swap_req,
   output logic               swap_ack,
   output logic [1:0]         out_kind,
   output logic [PORT_W-1:0]  out_port,
   output logic [1:0]         out_code
);

   initial begin
      assert (MAX_SLOTS >= 2 && (1 << ADDR_W) == MAX_SLOTS)
         else $error("calendar depth must be a power of two");
      assert (NPORT >= 2 && (1 << PORT_W) == NPORT)
         else $error("port count must be a power of two");
      assert (REP_W >= 1 && REP_W <= 16) else $error("repeat width out of range");
   end

   phase_t            phase;
   logic [ADDR_W-1:0] idx;
   logic              bank;
   logic              wr_ok;
   logic [PORT_W-1:0] rd_port;
   logic [1:0]        slot_code;
   logic [1:0]        dip;
   logic              in_slot;

   fcs_seq_ctrl #(.DEPTH(MAX_SLOTS), .REP_W(REP_W)) u_ctrl (
      .clk, .rst_n, .swap_req, .wr_en, .sh_len, .sh_rep,
      .phase, .idx, .bank, .wr_ok, .wr_err, .swap_ack
   );

   fcs_cal_store #(.DEPTH(MAX_SLOTS), .PORT_W(PORT_W)) u_store (
      .clk, .act_bank(bank), .wr_ok, .wr_addr, .wr_data,
      .rd_addr(idx), .rd_port
   );

   assign in_slot = (phase == PH_SLOT);

   fcs_status_path #(.NPORT(NPORT)) u_stat (
      .clk, .rst_n, .port_stat, .port(rd_port),
      .clr(phase == PH_FRAME), .slot_en(in_slot),
      .slot_code, .dip
   );

   assign out_kind = phase;
   assign out_port = in_slot ? rd_port : '0;

   always_comb begin
      unique case (phase)
         PH_IDLE:  out_code = 2'b00;
         PH_FRAME: out_code = FRAME_CODE;
         PH_SLOT:  out_code = slot_code;
         PH_DIP:   out_code = dip;
      endcase
   end

endmodule

// File: tb/fc_cal_seq_test.sv
module fc_cal_seq_test;

   localparam int DEPTH = 1024;
   localparam int NPORT = 256;
   localparam int REP_W = 4;
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int LEN_W  = $clog2(DEPTH + 1);
   localparam int PORT_W = $clog2(NPORT);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2*NPORT-1:0] port_stat = '0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [PORT_W-1:0] wr_data = '0;
   logic wr_err;
   logic [LEN_W-1:0] sh_len = '0;
   logic [REP_W-1:0] sh_rep = '0;
   logic swap_req = 1'b0;
   logic swap_ack;
   logic [1:0] out_kind;
   logic [PORT_W-1:0] out_port;
   logic [1:0] out_code;

   always #2 clk = ~clk;

   fc_cal_seq #(.MAX_SLOTS(DEPTH), .NPORT(NPORT), .REP_W(REP_W)) uut (.*);

   int checks = 0;
   int errors = 0;
   int act_m [DEPTH];
   int sh_m [DEPTH];
   int act_len = 1;
   int act_rep = 1;
   int unsigned seed_dummy;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int eff_len(int raw);
      if (raw == 0) return 1;
      if (raw > DEPTH) return DEPTH;
      return raw;
   endfunction

   function automatic int sent_code(int p);
      int v = int'(port_stat[2*p +: 2]);
      return (v == 3) ? 0 : v;
   endfunction

   task automatic model_swap();
      for (int i = 0; i < DEPTH; i++) begin
         int t = act_m[i];
         act_m[i] = sh_m[i];
         sh_m[i] = t;
      end
      act_len = eff_len(int'(sh_len));
      act_rep = (sh_rep == 0) ? 1 : int'(sh_rep);
   endtask

   task automatic rand_stat();
      for (int p = 0; p < NPORT; p++) port_stat[2*p +: 2] = 2'($urandom % 4);
   endtask

   task automatic write_entry(int a, int d);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = PORT_W'(d);
      sh_m[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic sync_frame();
      while (out_kind != 2'd1) @(negedge clk);
   endtask

   // checks one full sequence starting at its framing word; optional swap request
   task automatic run_seq(int req_at, bit exp_ack);
      int total = act_len * act_rep;
      int dip = 0;
      bit exp_err = 1'b0;
      check("R2 framing kind", int'(out_kind), 1);
      check("R2 framing code", int'(out_code), 3);
      check("R7 ack at frame", int'(swap_ack), int'(exp_ack));
      wr_en = 1'b0; swap_req = 1'b0;
      rand_stat();
      for (int c = 0; c <= total; c++) begin
         @(negedge clk);
         if (c < total) begin
            int p = act_m[c % act_len];
            int e = sent_code(p);
            check("R3 slot kind", int'(out_kind), 2);
            check("R3 R6 slot port", int'(out_port), p);
            check("R4 slot code", int'(out_code), e);
            dip ^= e;
         end else begin
            check("R2 parity kind", int'(out_kind), 3);
            check("R5 parity code", int'(out_code), dip);
         end
         check("R8 write error flag", int'(wr_err), int'(exp_err));
         wr_en = 1'b0; swap_req = 1'b0; exp_err = 1'b0;
         if (c == 0 && c < total) begin
            int d = int'($urandom % NPORT);
            wr_en = 1'b1; wr_addr = '0; wr_data = PORT_W'(d);
            sh_m[0] = d;
         end
         if (c == req_at) swap_req = 1'b1;
         if (req_at >= 0 && c == req_at + 1) begin
            wr_en = 1'b1; wr_addr = '0; wr_data = PORT_W'(sh_m[0] ^ 8'h5a);
            exp_err = 1'b1;   // R8: rejected, model unchanged
         end
      end
      @(negedge clk);
      check("R8 write error flag", int'(wr_err), int'(exp_err));
      wr_en = 1'b0; swap_req = 1'b0;
      if (req_at >= 0) model_swap();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'h1c5a7e01);
      for (int i = 0; i < DEPTH; i++) begin act_m[i] = 0; sh_m[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset
      repeat (2) begin
         @(negedge clk);
         check("R1 idle kind", int'(out_kind), 0);
         check("R1 idle code", int'(out_code), 0);
         check("R1 idle port", int'(out_port), 0);
         check("R1 idle ack", int'(swap_ack), 0);
         check("R1 idle err", int'(wr_err), 0);
      end
      // first calendar: 4 entries, repeated twice
      for (int i = 0; i < 4; i++) write_entry(i, 10 + 17 * i);
      sh_len = 11'd4; sh_rep = 4'd2;
      swap_req = 1'b1;
      @(negedge clk);
      swap_req = 1'b0;
      check("R10 still idle after request", int'(out_kind), 0);
      @(negedge clk);
      model_swap();
      run_seq(-1, 1'b1);
      run_seq(-1, 1'b0);
      // second calendar written while the first runs (R6), swap mid-sequence (R7)
      for (int i = 0; i < 3; i++) write_entry(i, 200 + i);
      sync_frame();
      sh_len = 11'd3; sh_rep = 4'd1;
      run_seq(1, 1'b0);
      sh_len = 11'd9; sh_rep = 4'd3;      // R9: ignored until next swap
      run_seq(-1, 1'b1);
      run_seq(-1, 1'b0);
      // zero length and zero repeat clamp to one (R9)
      write_entry(0, 77);
      sync_frame();
      sh_len = 11'd0; sh_rep = 4'd0;
      run_seq(0, 1'b0);
      run_seq(-1, 1'b1);
      // full depth through an over-range length; blocked write lands in parity cycle
      for (int i = 0; i < DEPTH; i++) write_entry(i, int'($urandom % NPORT));
      sync_frame();
      sh_len = 11'd2047; sh_rep = 4'd1;
      run_seq(0, 1'b0);
      check("R9 clamped length", act_len, DEPTH);
      run_seq(-1, 1'b1);
      // random calendars with random request positions
      for (int it = 0; it < 20; it++) begin
         int nl = 1 + int'($urandom % 16);
         int nr = 1 + int'($urandom % 4);
         for (int i = 0; i < nl; i++) write_entry(i, int'($urandom % NPORT));
         sync_frame();
         sh_len = LEN_W'(nl); sh_rep = REP_W'(nr);
         run_seq(int'($urandom % (act_len * act_rep)), 1'b0);
         sh_len = LEN_W'($urandom); sh_rep = REP_W'($urandom);
         run_seq(-1, 1'b1);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule